// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers fifteen single-cycle event pulses, one per interrupt source, and holds each one in its own pending flop until the CPU takes it, software clears it, or reset arrives. Each source is numbered 1 to 15. Number 1 is the supply monitor, 2 to 9 are the eight digital blocks, 10 to 13 are the four analog columns, 14 is the GPIO group and 15 is the sleep timer. A lower number means a higher priority.

A pending source can only raise a request when its mask bit is set and the CPU's global interrupt-enable flag is high. The mask bits are spread over two 8-bit registers, written through a small register write port. When a request is raised, the block presents the vector of the winning source, which is four times its number (0x0004 to 0x003C). When no request is raised, it presents 0x0000.

An acknowledge strobe from the CPU retires the source whose vector is on the output in that cycle. Any write to the vector/clear register drops every pending bit. The sources reach the block already qualified, so edge or level selection for pins and analog source selection happen elsewhere.

Top module: `irq_vector_ctrl`

## Requirements
- R1: A pulse on `src_evt_i[k]` sets the pending bit of source number k+1 at the next rising edge. If that source is unmasked and `global_ie_i` is 1, `irq_req_o` is 1 in the following cycle.
- R2: A pending bit keeps its value over any number of idle cycles. It is cleared only by an acknowledge that takes it, a write to the clear register, or reset.
- R3: `irq_req_o` is 1 only if `global_ie_i` is 1 and at least one pending source has its mask bit set. Masked or globally disabled sources stay pending and raise the request once they are enabled.
- R4: When several enabled sources are pending, the one with the lowest number wins.
- R5: `irq_vec_o` equals 4×n for the winning number n (16 bits wide). It is 0x0000 whenever `irq_req_o` is 0.
- R6: The mask registers are laid out as follows.
  - Address 0 (digital mask): bit b enables source b+2, for b = 0..7.
  - Address 1 (system mask): bit 0 enables source 1, bits 1 to 4 enable sources 10 to 13, bit 5 enables source 14 and bit 6 enables source 15. Bit 7 has no effect.
  - A mask write takes effect in the next cycle.
- R7: Any write to address 2 (the vector/clear register) clears every pending bit, whatever the data. An event arriving in the same cycle still sets its bit. A write to address 3 has no effect.
- R8: When `ack_i` is 1 and `irq_req_o` is 1, only the winning source's pending bit is cleared. An event on that same source in the same cycle keeps the bit set. When `irq_req_o` is 0, `ack_i` has no effect.
- R9: The synchronous active-high reset `rst` clears all pending bits and both mask registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_evt_i | input | 15 | Event pulses; bit k is source number k+1 |
| global_ie_i | input | 1 | Global interrupt enable from the CPU flags |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address (0 digital mask, 1 system mask, 2 vector/clear) |
| reg_wdata_i | input | 8 | Register write data |
| ack_i | input | 1 | CPU acknowledge of the presented vector |
| irq_req_o | output | 1 | Interrupt request to the CPU |
| irq_vec_o | output | 16 | Vector of the winning source, or 0 |

## Verification
Event pulses, mask writes, clear writes and acknowledges all act on registers, so their effect on `irq_req_o` and `irq_vec_o` appears one cycle after the edge that samples them. `global_ie_i` is combinational and gates the outputs within the same cycle. The bench drives every input on the falling edge and compares both outputs 1 ns later, still before the next rising edge, against a bench model. The model applies each edge's effects only after that comparison, so every check sees the state due in that cycle.

// File: rtl/irqv_pkg.sv
`timescale 1ns/1ps
package irqv_pkg;

  // default geometry
  localparam int SRC_N      = 15;
  localparam int VEC_W      = 16;
  localparam int VEC_STRIDE = 4;
  localparam int REG_DW     = 8;
  localparam int REG_AW     = 2;

  // register addresses
  localparam logic [REG_AW-1:0] REG_MASK_DIG = 2'd0;
  localparam logic [REG_AW-1:0] REG_MASK_SYS = 2'd1;
  localparam logic [REG_AW-1:0] REG_VEC_CLR  = 2'd2;

  // source numbering
  localparam int NUM_SUPPLY = 1;
  localparam int DIG_FIRST  = 2;
  localparam int DIG_N      = 8;
  localparam int ANA_FIRST  = 10;
  localparam int ANA_N      = 4;
  localparam int NUM_GPIO   = 14;
  localparam int NUM_SLEEP  = 15;

  // system mask bit positions
  localparam int SYS_BIT_SUPPLY = 0;
  localparam int SYS_BIT_ANA0   = 1;
  localparam int SYS_BIT_GPIO   = 5;
  localparam int SYS_BIT_SLEEP  = 6;
  localparam int SYS_USED       = 7;

  typedef struct packed {
    logic       in_sys;
    logic [2:0] pos;
  } mask_loc_t;

  // where the mask bit of a source number lives
  function automatic mask_loc_t mask_loc(input int num);
    mask_loc_t l;
    l.in_sys = 1'b1;
    l.pos    = 3'd0;
    if (num >= DIG_FIRST && num < DIG_FIRST + DIG_N) begin
      l.in_sys = 1'b0;
      l.pos    = 3'(num - DIG_FIRST);
    end else if (num == NUM_SUPPLY) begin
      l.pos = 3'(SYS_BIT_SUPPLY);
    end else if (num >= ANA_FIRST && num < ANA_FIRST + ANA_N) begin
      l.pos = 3'(SYS_BIT_ANA0 + num - ANA_FIRST);
    end else if (num == NUM_GPIO) begin
      l.pos = 3'(SYS_BIT_GPIO);
    end else if (num == NUM_SLEEP) begin
      l.pos = 3'(SYS_BIT_SLEEP);
    end
    return l;
  endfunction

  // vector address of a source number
  function automatic logic [VEC_W-1:0] vec_of(input int num);
    return VEC_W'(num * VEC_STRIDE);
  endfunction

endpackage

// File: rtl/irqv_mask_regs.sv
`timescale 1ns/1ps
module irqv_mask_regs
  import irqv_pkg::*;
#(
  parameter int P_SRC_N  = SRC_N,
  parameter int P_REG_DW = REG_DW
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [REG_AW-1:0]     addr,
  input  logic [P_REG_DW-1:0]   wdata,
  output logic [P_SRC_N-1:0]    src_mask
);

  logic [P_REG_DW-1:0] dig_q;
  logic [SYS_USED-1:0] sys_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dig_q <= '0;
      sys_q <= '0;
    end else if (we) begin
      if (addr == REG_MASK_DIG) dig_q <= wdata;
      if (addr == REG_MASK_SYS) sys_q <= wdata[SYS_USED-1:0];
    end
  end

  for (genvar i = 0; i < P_SRC_N; i++) begin : g_map
    localparam mask_loc_t LOC = mask_loc(i + 1);
    if (LOC.in_sys) begin : g_sys
      assign src_mask[i] = sys_q[LOC.pos];
    end else begin : g_dig
      assign src_mask[i] = dig_q[LOC.pos];
    end
  end

endmodule

// File: rtl/irqv_pending_bank.sv
`timescale 1ns/1ps
module irqv_pending_bank #(
  parameter int P_SRC_N = 15
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [P_SRC_N-1:0] evt,
  input  logic               clr_all,
  input  logic [P_SRC_N-1:0] retire,
  output logic [P_SRC_N-1:0] pend
);

  for (genvar i = 0; i < P_SRC_N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)                        pend[i] <= 1'b0;
      else if (evt[i])                pend[i] <= 1'b1;
      else if (clr_all || retire[i])  pend[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/irqv_prio_pick.sv
`timescale 1ns/1ps
module irqv_prio_pick
  import irqv_pkg::*;
#(
  parameter int P_SRC_N = SRC_N,
  parameter int P_VEC_W = VEC_W,
  localparam int NUM_W  = $clog2(P_SRC_N + 1)
) (
  input  logic [P_SRC_N-1:0] cand,
  output logic               any,
  output logic [P_SRC_N-1:0] win_oh,
  output logic [P_VEC_W-1:0] vec
);

  logic [NUM_W-1:0] win_num;

  always_comb begin
    any     = 1'b0;
    win_oh  = '0;
    win_num = '0;
    for (int i = 0; i < P_SRC_N; i++) begin
      if (cand[i] && !any) begin
        any       = 1'b1;
        win_oh[i] = 1'b1;
        win_num   = NUM_W'(i + 1);
      end
    end
  end

  assign vec = any ? P_VEC_W'(vec_of(int'(win_num))) : '0;

endmodule

// File: rtl/irq_vector_ctrl.sv
`timescale 1ns/1ps
module irq_vector_ctrl
  import irqv_pkg::*;
#(
  parameter int P_SRC_N  = SRC_N,
  parameter int P_VEC_W  = VEC_W,
  parameter int P_REG_DW = REG_DW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [P_SRC_N-1:0]   src_evt_i,
  input  logic                 global_ie_i,
  input  logic                 reg_we_i,
  input  logic [REG_AW-1:0]    reg_addr_i,
  input  logic [P_REG_DW-1:0]  reg_wdata_i,
  input  logic                 ack_i,
  output logic                 irq_req_o,
  output logic [P_VEC_W-1:0]   irq_vec_o
);

  logic [P_SRC_N-1:0] src_mask;
  logic [P_SRC_N-1:0] pend;
  logic [P_SRC_N-1:0] cand;
  logic [P_SRC_N-1:0] win_oh;
  logic [P_SRC_N-1:0] retire;
  logic               any_req;
  logic               clr_all;   // named event: clear-register write
  logic               ack_take;  // named event: acknowledge accepted

  assign clr_all  = reg_we_i && (reg_addr_i == REG_VEC_CLR);
  assign cand     = pend & src_mask & {P_SRC_N{global_ie_i}};
  assign ack_take = ack_i && any_req;
  assign retire   = win_oh & {P_SRC_N{ack_take}};

  irqv_mask_regs #(.P_SRC_N(P_SRC_N), .P_REG_DW(P_REG_DW)) u_mask (
    .clk(clk), .rst(rst), .we(reg_we_i), .addr(reg_addr_i),
    .wdata(reg_wdata_i), .src_mask(src_mask)
  );

  irqv_pending_bank #(.P_SRC_N(P_SRC_N)) u_pend (
    .clk(clk), .rst(rst), .evt(src_evt_i), .clr_all(clr_all),
    .retire(retire), .pend(pend)
  );

  irqv_prio_pick #(.P_SRC_N(P_SRC_N), .P_VEC_W(P_VEC_W)) u_pick (
    .cand(cand), .any(any_req), .win_oh(win_oh), .vec(irq_vec_o)
  );

  assign irq_req_o = any_req;

endmodule

// File: rtl/irqv_checker.sv
`timescale 1ns/1ps
module irqv_checker
  import irqv_pkg::*;
#(
  parameter int P_SRC_N = SRC_N,
  parameter int P_VEC_W = VEC_W
) (
  input logic               clk,
  input logic               rst,
  input logic [P_SRC_N-1:0] src_evt_i,
  input logic               global_ie_i,
  input logic               reg_we_i,
  input logic               ack_i,
  input logic               irq_req_o,
  input logic [P_VEC_W-1:0] irq_vec_o,
  input logic               clr_all,
  input logic               ack_take
);

  localparam logic [P_VEC_W-1:0] VMIN = P_VEC_W'(VEC_STRIDE);
  localparam logic [P_VEC_W-1:0] VMAX = P_VEC_W'(P_SRC_N * VEC_STRIDE);

  logic win_evt;
  always_comb begin
    win_evt = 1'b0;
    for (int i = 0; i < P_SRC_N; i++)
      if (irq_vec_o == P_VEC_W'((i + 1) * VEC_STRIDE)) win_evt = src_evt_i[i];
  end

  AST_REQ_NEEDS_IE: assert property (@(posedge clk) disable iff (rst)
    irq_req_o |-> global_ie_i);  // R3

  AST_VEC_IN_TABLE: assert property (@(posedge clk) disable iff (rst)
    irq_req_o |-> ((irq_vec_o % VMIN) == '0 && irq_vec_o >= VMIN && irq_vec_o <= VMAX));  // R5

  AST_IDLE_VEC_ZERO: assert property (@(posedge clk) disable iff (rst)
    !irq_req_o |-> (irq_vec_o == '0));  // R5

  AST_CLEAR_DROPS_ALL: assert property (@(posedge clk) disable iff (rst)
    (clr_all && src_evt_i == '0) |=> !irq_req_o);  // R7

  AST_ACK_RETIRES_WINNER: assert property (@(posedge clk) disable iff (rst)
    (ack_take && !win_evt) |=> (irq_vec_o != $past(irq_vec_o)));  // R8

  AST_PENDING_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (irq_req_o && !ack_i && !reg_we_i) |=> (irq_req_o || !global_ie_i));  // R2

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> !irq_req_o);  // R9

endmodule

bind irq_vector_ctrl irqv_checker #(.P_SRC_N(P_SRC_N), .P_VEC_W(P_VEC_W)) u_chk (
  .clk(clk), .rst(rst), .src_evt_i(src_evt_i), .global_ie_i(global_ie_i),
  .reg_we_i(reg_we_i), .ack_i(ack_i), .irq_req_o(irq_req_o),
  .irq_vec_o(irq_vec_o), .clr_all(clr_all), .ack_take(ack_take)
);

// File: tb/irq_vector_ctrl_bench.sv
`timescale 1ns/1ps
module irq_vector_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [14:0] evt = '0;
  logic        ie = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        ack = 1'b0;
  logic        irq_req;
  logic [15:0] irq_vec;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // bench model state
  logic [14:0] m_pend = '0;
  logic [7:0]  m_dig = '0;
  logic [7:0]  m_sys = '0;

  always #4 clk = ~clk;  // 125 MHz

  irq_vector_ctrl u_irq_vector_ctrl (
    .clk(clk), .rst(rst), .src_evt_i(evt), .global_ie_i(ie),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .ack_i(ack), .irq_req_o(irq_req), .irq_vec_o(irq_vec)
  );

  // R6 mask layout as written in the requirement
  function automatic logic mask_of(input int n);
    if (n == 1)             return m_sys[0];
    if (n >= 2 && n <= 9)   return m_dig[n-2];
    if (n >= 10 && n <= 13) return m_sys[n-9];
    if (n == 14)            return m_sys[5];
    return m_sys[6];
  endfunction

  function automatic int winner();
    if (!ie) return 0;
    for (int n = 1; n <= 15; n++)
      if (m_pend[n-1] && mask_of(n)) return n;
    return 0;
  endfunction

  task automatic compare(input logic er, input logic [15:0] ev, input string tag);
    checks++;
    if (irq_req !== er || irq_vec !== ev) begin
      failures++;
      $display("FAIL %s: req=%0b vec=%h expected req=%0b vec=%h", tag, irq_req, irq_vec, er, ev);
    end
  endtask

  // called at a falling edge with inputs set; checks, advances model, returns at next falling edge
  task automatic cyc(input string tag);
    int w;
    logic [14:0] nxt;
    #1;
    w = winner();
    compare(w != 0, (w != 0) ? 16'(4 * w) : 16'h0000, tag);
    if (rst) begin
      m_pend = '0; m_dig = '0; m_sys = '0;
    end else begin
      nxt = m_pend;
      if (we && addr == 2'd2) nxt = '0;
      if (ack && w != 0) nxt[w-1] = 1'b0;
      nxt = nxt | evt;
      if (we && addr == 2'd0) m_dig = wdata;
      if (we && addr == 2'd1) m_sys = wdata;
      m_pend = nxt;
    end
    @(posedge clk);
    @(negedge clk);
    evt = '0; we = 1'b0; ack = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input string tag);
    we = 1'b1; addr = a; wdata = d;
    cyc(tag);
  endtask

  task automatic fire(input logic [14:0] e, input string tag);
    evt = e;
    cyc(tag);
  endtask

  initial begin
    void'($urandom(32'd2718));
    @(posedge clk); @(posedge clk); @(negedge clk);
    rst = 1'b1; ie = 1'b1;
    cyc("R9 during reset");
    rst = 1'b0;
    compare(1'b0, 16'h0, "R9 reset state");
    // masks are zero after reset: events stay pending but no request
    fire(15'h7FFF, "R3 masked after reset");
    cyc("R3 masked, pending kept");
    wr(2'd2, 8'h00, "R7 clear");
    cyc("R7 cleared");

    wr(2'd0, 8'hFF, "R6 dig mask");
    wr(2'd1, 8'h7F, "R6 sys mask");
    cyc("R3 no pending");
    fire(15'h0010, "R1 source 5 pulse");
    #1 compare(1'b1, 16'h0014, "R1 source 5 request");
    cyc("R1");
    cyc("R2 hold");
    cyc("R2 hold");
    #1 compare(1'b1, 16'h0014, "R2 still pending");
    ie = 1'b0;
    #1 compare(1'b0, 16'h0000, "R3 global disable");
    cyc("R3");
    cyc("R3");
    ie = 1'b1;
    #1 compare(1'b1, 16'h0014, "R3 re-enable");
    fire(15'h0804, "R4 sources 3 and 12");
    #1 compare(1'b1, 16'h000C, "R4 lowest number wins");
    ack = 1'b1; cyc("R8 ack source 3");
    #1 compare(1'b1, 16'h0014, "R8 next is source 5");
    ack = 1'b1; evt = 15'h0010; cyc("R8 ack with same-source event");
    #1 compare(1'b1, 16'h0014, "R8 event keeps bit");
    ack = 1'b1; cyc("R8 ack source 5");
    #1 compare(1'b1, 16'h0030, "R8 next is source 12");
    ack = 1'b1; cyc("R8 ack source 12");
    #1 compare(1'b0, 16'h0000, "R8 all taken");
    ack = 1'b1; cyc("R8 ack with no request");
    fire(15'h4001, "R4 sources 1 and 15");
    #1 compare(1'b1, 16'h0004, "R4 supply first");
    ie = 1'b0; ack = 1'b1; cyc("R8 ack while disabled");
    ie = 1'b1;
    #1 compare(1'b1, 16'h0004, "R8 ack without request ignored");
    wr(2'd3, 8'hFF, "R7 address 3 write");
    #1 compare(1'b1, 16'h0004, "R7 address 3 no effect");
    evt = 15'h2000; wr(2'd2, 8'h5A, "R7 clear with event");
    #1 compare(1'b1, 16'h0038, "R7 event survives clear");
    wr(2'd2, 8'h00, "R7 clear");
    #1 compare(1'b0, 16'h0000, "R7 all cleared");

    // R6 one mask bit at a time
    for (int n = 1; n <= 15; n++) begin
      logic [7:0] d, s;
      d = '0; s = '0;
      if (n == 1) s[0] = 1'b1;
      else if (n <= 9) d[n-2] = 1'b1;
      else if (n <= 13) s[n-9] = 1'b1;
      else if (n == 14) s[5] = 1'b1;
      else s[6] = 1'b1;
      wr(2'd0, d, "R6 dig");
      wr(2'd1, s, "R6 sys");
      fire(15'h7FFF, "R6 all fire");
      #1 compare(1'b1, 16'(4 * n), $sformatf("R6 R5 vector of source %0d", n));
      wr(2'd2, 8'h00, "R7 clear");
    end
    wr(2'd0, 8'h00, "R6 dig off");
    wr(2'd1, 8'h80, "R6 sys bit 7 only");
    fire(15'h7FFF, "R6 all fire");
    #1 compare(1'b0, 16'h0000, "R6 bit 7 enables nothing");
    wr(2'd0, 8'hFF, "R6 dig on");
    rst = 1'b1; cyc("R9 reset mid-run");
    rst = 1'b0;
    #1 compare(1'b0, 16'h0000, "R9 pending and masks cleared");
    fire(15'h7FFF, "R9 fire after reset");
    #1 compare(1'b0, 16'h0000, "R9 masks cleared");

    // constrained random
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = $urandom % 8;
      if (r < 2)      evt = 15'(1 << ($urandom % 15));
      else if (r == 2) evt = 15'($urandom);
      else            evt = '0;
      if ($urandom % 16 == 0) begin
        we = 1'b1; addr = 2'($urandom); wdata = 8'($urandom);
      end
      ack = ($urandom % 3 == 0);
      ie  = ($urandom % 8 != 0);
      rst = ($urandom % 500 == 0);
      cyc("R4 random");
      rst = 1'b0;
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule